// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block is the arithmetic core of a 32-bit multiply-accumulate engine. It holds one 32-bit accumulator and an 8-bit mode/status register. On each cycle where `op_valid` is high it takes two 32-bit operands and a 2-bit operation code. It then adds the product to the accumulator, subtracts the product from it, forms a plain product without touching the accumulator, or loads the accumulator directly from operand A.

Operands are treated as integers or as signed fixed-point fractions. Integer arithmetic is signed or unsigned. Overflow of an accumulate can either wrap or saturate. Saturation is sticky: once it happens, later accumulates are ignored until the overflow flag is cleared. A combinational store path presents the accumulator as a general-purpose result. In fractional mode this result can be rounded to a 16-bit fraction, and the accumulator itself is left unchanged.

Top module: `mac_unit`

## Requirements
- R1: After a synchronous reset the accumulator, the product output and all eight mode/status bits are 0.
- R2: Mode/status register bit positions: 7 = saturation enable, 6 = unsigned select, 5 = fractional select, 4 = round select, 3 = N, 2 = Z, 1 = V, 0 = C. A register write sets bits 7..1 from the write data, and bit 0 always reads 0.
- R3: Operation codes are 00 = multiply-add, 01 = multiply-subtract, 10 = plain multiply and 11 = load. In integer mode, multiply-add and multiply-subtract combine the low 32 bits of A*B with the accumulator. With saturation disabled the result wraps. V is set when the result leaves the signed range (bit 6 = 0) or the unsigned range (bit 6 = 1).
- R4: With saturation enabled and signed arithmetic in force (bit 6 = 0, or fractional mode), an overflowing accumulate writes 0x7FFF_FFFF if the true result is above the range and 0x8000_0000 if it is below, and sets V.
- R5: With saturation enabled, integer mode and unsigned arithmetic, an overflowing multiply-add writes 0xFFFF_FFFF and an underflowing multiply-subtract writes 0x0000_0000.
- R6: While saturation is enabled and V is 1, multiply-add and multiply-subtract leave the accumulator and N/Z unchanged. Clearing V by a register write, or by a load, resumes normal accumulation.
- R7: A load copies A into the accumulator, clears V, and updates N and Z.
- R8: N (result msb) and Z (result == 0) are updated only by multiply-add, multiply-subtract and load. A plain multiply leaves the accumulator and the flags unchanged and places the product on `mul_o`.
- R9: In fractional mode the product is the upper 32 bits of the signed 64-bit product shifted left by one. It is truncated for multiply-add, for plain multiply, and for multiply-subtract when bit 4 = 0.
- R10: In fractional mode with bit 4 = 1, multiply-subtract rounds the shifted product to nearest. An exact half (discarded low word = 0x8000_0000) rounds to the even upper word.
- R11: `store_o` equals the accumulator, except in fractional mode with bit 6 = 1. There it is the accumulator rounded to its upper 16 bits (round to nearest, ties to even), placed in bits 15..0 with bits 31..16 zero, and the accumulator is not modified.
- R12: An operation presented with `op_valid` is reflected on `acc_o`, `mul_o` and `csr_rdata` after exactly one rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 2 | Operation select (see R3) |
| op_a | input | 32 | Operand A / load value |
| op_b | input | 32 | Operand B |
| csr_we | input | 1 | Mode/status register write enable |
| csr_wdata | input | 8 | Mode/status register write data |
| csr_rdata | output | 8 | Mode/status register contents |
| acc_o | output | 32 | Accumulator contents |
| mul_o | output | 32 | Result of the last plain multiply |
| store_o | output | 32 | Accumulator as formatted for a register store |

## Verification
The assertions assume that a register write and an operation never fall in the same cycle. A write could legally set V or change the mode under an operation, and the flag and freeze properties exempt only that case. The stimulus issues every register write and every operation in separate cycles. It covers wrap, both saturation directions in both signedness modes, the freeze and its release, and exact-half rounding ties. It also includes a long mixed run of random operands and modes, so the properties see both frozen and active accumulation.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [1:0] {
    OP_MAC  = 2'b00,
    OP_MSAC = 2'b01,
    OP_MUL  = 2'b10,
    OP_LOAD = 2'b11
  } mac_op_e;

  typedef struct packed {
    logic sat_en;
    logic uns;
    logic frac;
    logic rnd;
    logic n;
    logic z;
    logic v;
    logic c;
  } mode_t;
endpackage

// File: rtl/mac_product.sv
module mac_product #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         frac_i,
  input  logic         round_i,
  output logic [W-1:0] prod_o
);
  localparam int PW = 2 * W;

  logic signed [PW-1:0] full;
  logic [PW-1:0]        shifted;
  logic [W-1:0]         hi, lo;
  logic                 inc;

  assign full    = $signed({{W{a_i[W-1]}}, a_i}) * $signed({{W{b_i[W-1]}}, b_i});
  assign shifted = {full[PW-2:0], 1'b0};
  assign hi      = shifted[PW-1:W];
  assign lo      = shifted[W-1:0];
  // nearest, ties to even upper word
  assign inc     = round_i & lo[W-1] & ((|lo[W-2:0]) | hi[0]);

  always_comb begin
    if (frac_i) prod_o = hi + {{(W-1){1'b0}}, inc};
    else        prod_o = full[W-1:0];
  end
endmodule

// File: rtl/mac_accum.sv
module mac_accum #(
  parameter int W = 32
) (
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] prod_i,
  input  logic         sub_i,
  input  logic         signed_i,
  output logic [W-1:0] sum_o,
  output logic         ovf_o,
  output logic [W-1:0] sat_o
);
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  logic [W:0] ea, ep, r;

  assign ea = signed_i ? {acc_i[W-1], acc_i}   : {1'b0, acc_i};
  assign ep = signed_i ? {prod_i[W-1], prod_i} : {1'b0, prod_i};
  assign r  = sub_i ? (ea - ep) : (ea + ep);
  assign sum_o = r[W-1:0];

  always_comb begin
    if (signed_i) begin
      ovf_o = r[W] ^ r[W-1];
      sat_o = r[W] ? SMIN : SMAX;
    end else begin
      ovf_o = r[W];
      sat_o = sub_i ? '0 : '1;
    end
  end
endmodule

// File: rtl/mac_store.sv
module mac_store #(
  parameter int W = 32
) (
  input  logic [W-1:0] acc_i,
  input  logic         half_i,
  output logic [W-1:0] store_o
);
  localparam int H = W / 2;

  logic [H-1:0] top, bot, rounded;
  logic         inc;

  assign top     = acc_i[W-1:H];
  assign bot     = acc_i[H-1:0];
  assign inc     = bot[H-1] & ((|bot[H-2:0]) | top[0]);
  assign rounded = top + {{(H-1){1'b0}}, inc};
  assign store_o = half_i ? {{(W-H){1'b0}}, rounded} : acc_i;
endmodule

// File: rtl/mac_unit.sv
module mac_unit #(
  parameter int W  = 32,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_valid,
  input  logic [1:0]    op_code,
  input  logic [W-1:0]  op_a,
  input  logic [W-1:0]  op_b,
  input  logic          csr_we,
  input  logic [CW-1:0] csr_wdata,
  output logic [CW-1:0] csr_rdata,
  output logic [W-1:0]  acc_o,
  output logic [W-1:0]  mul_o,
  output logic [W-1:0]  store_o
);
  import mac_pkg::*;

  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  mode_t    mode_q;
  mac_op_e  op;
  logic [W-1:0] acc_q, mul_q, prod, sum, sat, acc_nx;
  logic     is_acc, is_sub, arith_signed, frozen, ovf, rnd_en;

  assign op           = mac_op_e'(op_code);
  assign is_sub       = (op == OP_MSAC);
  assign is_acc       = (op == OP_MAC) || is_sub;
  assign arith_signed = mode_q.frac | ~mode_q.uns;
  assign frozen       = mode_q.sat_en & mode_q.v;
  assign rnd_en       = mode_q.frac & mode_q.rnd & is_sub;

  mac_product #(.W(W)) u_prod (
    .a_i(op_a), .b_i(op_b), .frac_i(mode_q.frac),
    .round_i(rnd_en), .prod_o(prod)
  );

  mac_accum #(.W(W)) u_acc (
    .acc_i(acc_q), .prod_i(prod), .sub_i(is_sub),
    .signed_i(arith_signed), .sum_o(sum), .ovf_o(ovf), .sat_o(sat)
  );

  mac_store #(.W(W)) u_store (
    .acc_i(acc_q), .half_i(mode_q.frac & mode_q.uns), .store_o(store_o)
  );

  assign acc_nx = (ovf && mode_q.sat_en) ? sat : sum;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      mul_q  <= '0;
      mode_q <= '0;
    end else begin
      if (op_valid) begin
        unique case (op)
          OP_LOAD: begin
            acc_q    <= op_a;
            mode_q.n <= op_a[W-1];
            mode_q.z <= (op_a == '0);
            mode_q.v <= 1'b0;
          end
          OP_MUL: mul_q <= prod;
          default: begin
            if (!frozen) begin
              acc_q    <= acc_nx;
              mode_q.n <= acc_nx[W-1];
              mode_q.z <= (acc_nx == '0);
              if (ovf) mode_q.v <= 1'b1;
            end
          end
        endcase
      end
      if (csr_we) mode_q <= mode_t'({csr_wdata[CW-1:1], 1'b0});
    end
  end

  assign csr_rdata = mode_q;
  assign acc_o     = acc_q;
  assign mul_o     = mul_q;

  // R6: frozen accumulator ignores accumulates
  p_frozen_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (op_valid && is_acc && frozen) |=> $stable(acc_q));

  // R7: load writes A and clears V
  p_load_clears_v_r7: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op == OP_LOAD && !csr_we) |=> (!mode_q.v && acc_q == $past(op_a)));

  // R8: plain multiply leaves accumulator and flags
  p_mul_keeps_state_r8: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op == OP_MUL && !csr_we) |=>
      ($stable(acc_q) && $stable(mode_q.n) && $stable(mode_q.z) && $stable(mode_q.v)));

  // R8: Z and N follow the accumulator after flag-updating ops
  p_flags_track_r8: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op != OP_MUL && !csr_we) |=>
      (mode_q.z == (acc_q == '0) && mode_q.n == acc_q[W-1]));

  // R4, R5: fresh saturation lands on a limit value
  p_sat_limit_r4: assert property (@(posedge clk) disable iff (rst)
    ($rose(mode_q.v) && mode_q.sat_en && !$past(csr_we)) |->
      (acc_q == SMAX || acc_q == SMIN || acc_q == '0 || acc_q == '1));
endmodule

// File: tb/tb_mac_unit.sv
module tb_mac_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst = 1;
  logic        op_valid = 0, csr_we = 0;
  logic [1:0]  op_code = 0;
  logic [31:0] op_a = 0, op_b = 0;
  logic [7:0]  csr_wdata = 0, csr_rdata;
  logic [31:0] acc_o, mul_o, store_o;

  mac_unit dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .op_a(op_a), .op_b(op_b), .csr_we(csr_we), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .acc_o(acc_o), .mul_o(mul_o), .store_o(store_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [31:0] acc;
    logic [31:0] mul;
    logic [31:0] st;
    logic [7:0]  csr;
    string       tag;
  } exp_t;

  exp_t q[$];
  int vectors = 0, miscompares = 0;

  logic [31:0] m_acc = 0, m_mul = 0;
  logic [7:0]  m_csr = 0;

  function automatic logic [31:0] m_store(logic [31:0] a, logic [7:0] c);
    logic [15:0] t;
    if (c[5] && c[6]) begin
      t = a[31:16];
      if (a[15:0] > 16'h8000 || (a[15:0] == 16'h8000 && t[0])) t = t + 16'd1;
      return {16'h0, t};
    end
    return a;
  endfunction

  function automatic logic [31:0] m_prod(logic [31:0] a, logic [31:0] b,
                                         logic frac, logic rnd);
    longint full;
    logic [63:0] sh;
    logic [31:0] hi, lo;
    if (!frac) return a * b;
    full = longint'($signed(a)) * longint'($signed(b));
    sh = 64'(full) << 1;
    hi = sh[63:32];
    lo = sh[31:0];
    if (rnd && (lo > 32'h8000_0000 || (lo == 32'h8000_0000 && hi[0]))) hi = hi + 1;
    return hi;
  endfunction

  task automatic push(string tag);
    exp_t e;
    e.acc = m_acc; e.mul = m_mul; e.csr = m_csr;
    e.st = m_store(m_acc, m_csr); e.tag = tag;
    q.push_back(e);
  endtask

  task automatic wr_csr(logic [7:0] d, string tag);
    @(negedge clk);
    op_valid = 0; csr_we = 1; csr_wdata = d;
    m_csr = d & 8'hFE;
    push(tag);
  endtask

  task automatic do_op(logic [1:0] code, logic [31:0] a, logic [31:0] b, string tag);
    logic frac, sub, sgn, ovf;
    logic [31:0] p, nx, sat;
    longint s;
    @(negedge clk);
    csr_we = 0; op_valid = 1; op_code = code; op_a = a; op_b = b;
    frac = m_csr[5]; sub = (code == 2'b01); sgn = frac | ~m_csr[6];
    case (code)
      2'b11: begin m_acc = a; m_csr[3] = a[31]; m_csr[2] = (a == 0); m_csr[1] = 0; end
      2'b10: m_mul = m_prod(a, b, frac, 1'b0);
      default: if (!(m_csr[7] && m_csr[1])) begin
        p = m_prod(a, b, frac, frac & m_csr[4] & sub);
        if (sgn) begin
          s = sub ? longint'($signed(m_acc)) - longint'($signed(p))
                  : longint'($signed(m_acc)) + longint'($signed(p));
          ovf = (s > 64'sd2147483647) || (s < -64'sd2147483648);
          sat = (s > 0) ? 32'h7FFF_FFFF : 32'h8000_0000;
        end else begin
          s = sub ? longint'({32'h0, m_acc}) - longint'({32'h0, p})
                  : longint'({32'h0, m_acc}) + longint'({32'h0, p});
          ovf = (s < 0) || (s > 64'sh0_FFFF_FFFF);
          sat = sub ? 32'h0 : 32'hFFFF_FFFF;
        end
        nx = (ovf && m_csr[7]) ? sat : s[31:0];
        m_acc = nx; m_csr[3] = nx[31]; m_csr[2] = (nx == 0);
        if (ovf) m_csr[1] = 1;
      end
    endcase
    push(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    op_valid = 0; csr_we = 0;
  endtask

  task automatic expect32(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compare one item per edge that carried a pushed stimulus (R12)
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      vectors++;
      if (acc_o !== e.acc || mul_o !== e.mul || csr_rdata !== e.csr || store_o !== e.st) begin
        miscompares++;
        $display("FAIL %s actual acc=%h mul=%h csr=%h st=%h expected acc=%h mul=%h csr=%h st=%h",
                 e.tag, acc_o, mul_o, csr_rdata, store_o, e.acc, e.mul, e.csr, e.st);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    expect32("R1", {24'h0, csr_rdata}, 32'h0);
    expect32("R1", acc_o, 32'h0);
    expect32("R1", mul_o, 32'h0);

    // R2 register layout, C reads 0
    wr_csr(8'hFF, "R2");
    wr_csr(8'h00, "R2");

    // R3 integer signed accumulate, R12 latency
    do_op(2'b11, 32'd10, 0, "R7");
    do_op(2'b00, 32'd3, 32'd4, "R3");
    do_op(2'b01, 32'd5, 32'd6, "R3");
    do_op(2'b00, 32'd2, 32'd4, "R3");
    idle();
    expect32("R3", acc_o, 32'd0);
    do_op(2'b11, 32'h7FFF_FFFF, 0, "R7");
    do_op(2'b00, 32'd1, 32'd1, "R3");
    idle();
    expect32("R3", acc_o, 32'h8000_0000);
    expect32("R3", {31'h0, csr_rdata[1]}, 32'h1);
    do_op(2'b11, 32'd5, 0, "R7");
    idle();
    expect32("R7", {31'h0, csr_rdata[1]}, 32'h0);

    // R4 signed saturation, R6 freeze and release
    wr_csr(8'h80, "R4");
    do_op(2'b11, 32'h7FFF_FFF0, 0, "R4");
    do_op(2'b00, 32'h100, 32'd1, "R4");
    idle();
    expect32("R4", acc_o, 32'h7FFF_FFFF);
    do_op(2'b00, 32'd1, 32'd1, "R6");
    do_op(2'b01, 32'd9, 32'd9, "R6");
    idle();
    expect32("R6", acc_o, 32'h7FFF_FFFF);
    wr_csr(8'h80, "R6");
    do_op(2'b01, 32'd1, 32'd1, "R6");
    idle();
    expect32("R6", acc_o, 32'h7FFF_FFFE);
    do_op(2'b11, 32'h8000_0005, 0, "R4");
    do_op(2'b01, 32'd10, 32'd1, "R4");
    idle();
    expect32("R4", acc_o, 32'h8000_0000);

    // R5 unsigned saturation
    wr_csr(8'hC0, "R5");
    do_op(2'b11, 32'hFFFF_FFF0, 0, "R5");
    do_op(2'b00, 32'h20, 32'd1, "R5");
    idle();
    expect32("R5", acc_o, 32'hFFFF_FFFF);
    do_op(2'b11, 32'd5, 0, "R6");
    do_op(2'b01, 32'd10, 32'd1, "R5");
    idle();
    expect32("R5", acc_o, 32'h0);

    // R8 plain multiply
    wr_csr(8'h00, "R8");
    do_op(2'b11, 32'd77, 0, "R8");
    do_op(2'b10, 32'd7, 32'hFFFF_FFFD, "R8");
    idle();
    expect32("R8", mul_o, 32'hFFFF_FFEB);
    expect32("R8", acc_o, 32'd77);

    // R9 fractional product
    wr_csr(8'h20, "R9");
    do_op(2'b10, 32'h4000_0000, 32'h4000_0000, "R9");
    idle();
    expect32("R9", mul_o, 32'h2000_0000);
    do_op(2'b11, 32'h100, 0, "R9");
    do_op(2'b01, 32'h18000, 32'h8000, "R9");
    idle();
    expect32("R9", acc_o, 32'hFF);

    // R10 rounding ties to even
    wr_csr(8'h30, "R10");
    do_op(2'b11, 32'h100, 0, "R10");
    do_op(2'b01, 32'h18000, 32'h8000, "R10");
    idle();
    expect32("R10", acc_o, 32'hFE);
    do_op(2'b01, 32'h8000, 32'h8000, "R10");
    idle();
    expect32("R10", acc_o, 32'hFE);

    // R11 store path
    wr_csr(8'h60, "R11");
    do_op(2'b11, 32'h1234_8000, 0, "R11");
    idle();
    expect32("R11", store_o, 32'h0000_1234);
    expect32("R11", acc_o, 32'h1234_8000);
    do_op(2'b11, 32'h1235_8000, 0, "R11");
    idle();
    expect32("R11", store_o, 32'h0000_1236);
    do_op(2'b11, 32'h1234_8001, 0, "R11");
    idle();
    expect32("R11", store_o, 32'h0000_1235);
    wr_csr(8'h40, "R11");
    idle();
    expect32("R11", store_o, 32'h1234_8001);

    // mixed random run across modes
    for (int i = 0; i < 600; i++) begin
      if (i % 25 == 0) wr_csr(8'($urandom) & 8'hF0, "R12");
      do_op(2'($urandom), (i % 3 == 0) ? $urandom : ($urandom & 32'h0001_FFFF),
            (i % 4 == 0) ? $urandom : ($urandom & 32'h0000_FFFF), "R12");
    end
    idle();
    idle();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule